// File: doc/BRIEF.md
# Verification-Gated Speculative Store Buffer

This block sits between a processor core and its first-level data cache. The code being run is split into authenticated instruction blocks. Any store issued before the current block has passed its integrity check is held back. Such a store is kept as an address/data pair, in issue order. It is released to the cache only once the verifier reports success. If the verifier reports a failure, every held store is dropped at once, so no store from unauthenticated code can change memory.

Once the block is verified, held entries go to the cache one per cycle, and only in cycles where the cache reports that it is idle. A store from a verified block goes straight to the cache only when nothing older is still waiting. Otherwise it joins the back of the queue. When the queue is full and no entry can leave in that cycle, the core is told to stall. A load-lookup port lets the core read the newest held value for an address before that value reaches the cache.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer is empty: `cpu_stall`, `dc_wr_en` and `ld_hit` are all 0.
- R2: A store presented while `blk_verified` is 0 is held in the buffer and produces no cache write.
- R3: A store presented while `blk_verified` is 1, the buffer is empty and `dc_idle` is 1 is written to the cache in the same cycle, with its own address and data, and is not held.
- R4: With `blk_verified` at 1 and `dc_idle` at 1, held entries are written to the cache one per cycle, oldest first.
- R5: While `dc_idle` is 0, no cache write occurs and held entries are kept.
- R6: A store arriving when the buffer is full and no entry leaves in that cycle raises `cpu_stall` and is not accepted. The stall drops in the first cycle in which an entry drains.
- R7: When `blk_fail` is 1, no cache write occurs in that cycle, `cpu_stall` is 0, and from the next cycle on every held entry is gone. `blk_fail` takes priority over `blk_verified`.
- R8: A store from a verified block that arrives while older entries are still held is queued behind them, so cache writes keep issue order.
- R9: `ld_hit` is 1 when `ld_addr` equals the address of a held entry, and `ld_data` is then the data of the youngest such entry. Otherwise `ld_hit` is 0.
- R10: The buffer holds up to DEPTH entries (default 8, a power of two, at least 2), and its full and empty flags come from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| blk_verified | input | 1 | Current instruction block has been authenticated |
| blk_fail | input | 1 | Authentication of the current block failed (one-cycle pulse) |
| dc_idle | input | 1 | Data cache can accept a write this cycle |
| dc_wr_en | output | 1 | Cache write strobe |
| dc_wr_addr | output | AW | Cache write address |
| dc_wr_data | output | DW | Cache write data |
| cpu_stall | output | 1 | Core must hold its current store |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | Lookup matched a held entry |
| ld_data | output | DW | Data of the youngest matching entry |

## Verification
The cache write, the stall and the lookup outputs are combinational from the inputs of the current cycle and the state registered at the last edge. So `dc_wr_en`, `cpu_stall` and `ld_hit` are due in the same cycle as the stimulus that causes them. A push, pop or flush shows up only one edge later, in the lookup result and in the drain order. The bench therefore drives inputs just after the falling edge and checks the same-cycle outputs 1 ns later. It checks any effect on held state only in the next cycle, after the rising edge that commits that state.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_DIRECT = 2'd1,
    WR_DRAIN  = 2'd2
  } wr_src_e;
endpackage

// File: rtl/ssb_fifo.sv
module ssb_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [AW-1:0]          push_addr,
  input  logic [DW-1:0]          push_data,
  input  logic                   pop,
  input  logic                   flush,
  output logic [AW-1:0]          head_addr,
  output logic [DW-1:0]          head_data,
  output logic                   full,
  output logic                   empty,
  output logic [DEPTH-1:0]       slot_valid,
  output logic [DEPTH*AW-1:0]    slot_addr,
  output logic [DEPTH*DW-1:0]    slot_data,
  output logic [$clog2(DEPTH)-1:0] wr_ptr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full_q, full_d, empty_q, empty_d;
  logic [DEPTH-1:0] vld_q, vld_d;

  // next-state
  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
      vld_d = '0;
    end else begin
      if (pop) begin
        vld_d[rd_q] = 1'b0;
        rd_d        = rd_q + PW'(1);
      end
      if (push) begin
        vld_d[wr_q] = 1'b1;
        wr_d        = wr_q + PW'(1);
      end
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
    full_d  = (cnt_d == CW'(DEPTH));
    empty_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      vld_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  // storage, enabled per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !flush && (wr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        addr_mem[g] <= push_addr;
        data_mem[g] <= push_data;
      end
    end
    assign slot_addr[g*AW +: AW] = addr_mem[g];
    assign slot_data[g*DW +: DW] = data_mem[g];
  end

  assign head_addr  = addr_mem[rd_q];
  assign head_data  = data_mem[rd_q];
  assign full       = full_q;
  assign empty      = empty_q;
  assign slot_valid = vld_q;
  assign wr_ptr     = wr_q;

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty_q);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_q) |-> pop);
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty_q && vld_q == '0));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    st_valid,
  input  logic    blk_verified,
  input  logic    blk_fail,
  input  logic    dc_idle,
  input  logic    full,
  input  logic    empty,
  output logic    push,
  output logic    pop,
  output logic    flush,
  output logic    stall,
  output wr_src_e wr_src
);
  logic may_write;
  logic direct;

  always_comb begin
    may_write = blk_verified && !blk_fail && dc_idle;
    pop       = may_write && !empty;
    direct    = may_write && empty && st_valid;
    flush     = blk_fail;
    stall     = st_valid && full && !pop && !blk_fail;
    push      = st_valid && !direct && !stall && !blk_fail;
    if (pop)         wr_src = WR_DRAIN;
    else if (direct) wr_src = WR_DIRECT;
    else             wr_src = WR_NONE;
  end

  assert_stall_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> full);
  assert_fail_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_fail |-> (wr_src == WR_NONE && !stall));
  assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src == WR_DIRECT) |-> empty);
endmodule

// File: rtl/ssb_lookup.sv
module ssb_lookup #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [AW-1:0]            ld_addr,
  input  logic [DEPTH-1:0]         slot_valid,
  input  logic [DEPTH*AW-1:0]      slot_addr,
  input  logic [DEPTH*DW-1:0]      slot_data,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic                     hit,
  output logic [DW-1:0]            data
);
  localparam int PW = $clog2(DEPTH);

  // scan oldest-to-youngest slot positions so the youngest match wins
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [PW-1:0] idx;
      idx = wr_ptr - PW'(k) - PW'(1);
      if (slot_valid[idx] && slot_addr[idx*AW +: AW] == ld_addr) begin
        hit  = 1'b1;
        data = slot_data[idx*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          blk_verified,
  input  logic          blk_fail,
  input  logic          dc_idle,
  output logic          dc_wr_en,
  output logic [AW-1:0] dc_wr_addr,
  output logic [DW-1:0] dc_wr_data,
  output logic          cpu_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data
);
  localparam int PW = $clog2(DEPTH);

  logic                push, pop, flush, full, empty;
  wr_src_e             wr_src;
  logic [AW-1:0]       head_addr;
  logic [DW-1:0]       head_data;
  logic [DEPTH-1:0]    slot_valid;
  logic [DEPTH*AW-1:0] slot_addr;
  logic [DEPTH*DW-1:0] slot_data;
  logic [PW-1:0]       wr_ptr;

  ssb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .blk_verified(blk_verified),
    .blk_fail(blk_fail), .dc_idle(dc_idle), .full(full), .empty(empty),
    .push(push), .pop(pop), .flush(flush), .stall(cpu_stall), .wr_src(wr_src)
  );

  ssb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr),
    .push_data(st_data), .pop(pop), .flush(flush), .head_addr(head_addr),
    .head_data(head_data), .full(full), .empty(empty), .slot_valid(slot_valid),
    .slot_addr(slot_addr), .slot_data(slot_data), .wr_ptr(wr_ptr)
  );

  ssb_lookup #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_lookup (
    .ld_addr(ld_addr), .slot_valid(slot_valid), .slot_addr(slot_addr),
    .slot_data(slot_data), .wr_ptr(wr_ptr), .hit(ld_hit), .data(ld_data)
  );

  always_comb begin
    dc_wr_en   = (wr_src != WR_NONE);
    dc_wr_addr = (wr_src == WR_DRAIN) ? head_addr : st_addr;
    dc_wr_data = (wr_src == WR_DRAIN) ? head_data : st_data;
  end

  assert_write_needs_verify_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dc_wr_en |-> (blk_verified && !blk_fail));
  assert_write_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dc_wr_en |-> dc_idle);
  assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop, (wr_src == WR_DIRECT)}));
endmodule

// File: tb/spec_store_buf_bench.sv
module spec_store_buf_bench;
  localparam int AW = 32, DW = 32, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, blk_verified = 1'b0, blk_fail = 1'b0, dc_idle = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, dc_wr_addr;
  logic [DW-1:0] st_data = '0, dc_wr_data, ld_data;
  logic dc_wr_en, cpu_stall, ld_hit;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spec_store_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_spec_store_buf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .blk_verified(blk_verified), .blk_fail(blk_fail),
    .dc_idle(dc_idle), .dc_wr_en(dc_wr_en), .dc_wr_addr(dc_wr_addr),
    .dc_wr_data(dc_wr_data), .cpu_stall(cpu_stall), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance to the next falling edge; inputs are then driven, outputs read 1 ns later
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 stall", cpu_stall, 0);
    chk("R1 wr_en", dc_wr_en, 0);
    chk("R1 hit", ld_hit, 0);
  endtask

  task automatic t_capture();
    blk_verified = 1'b0; dc_idle = 1'b1;
    for (int i = 0; i < 3; i++) begin
      store(32'h100 + 32'(4 * i), 32'hA0 + 32'(i));
      #1 chk("R2 no write while unverified", dc_wr_en, 0);
      cyc();
    end
    store(32'h104, 32'hBEEF);
    cyc();
    st_valid = 1'b0;
    ld_addr = 32'h104; #1;
    chk("R9 hit", ld_hit, 1);
    chk("R9 youngest data", ld_data, 32'hBEEF);
    ld_addr = 32'h100; #1;
    chk("R9 older entry data", ld_data, 32'hA0);
    ld_addr = 32'h200; #1;
    chk("R9 miss", ld_hit, 0);
  endtask

  task automatic t_busy();
    blk_verified = 1'b1; dc_idle = 1'b0;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R5 no write while busy", dc_wr_en, 0);
      cyc();
    end
    ld_addr = 32'h108; #1;
    chk("R5 entry kept", ld_hit, 1);
  endtask

  task automatic t_drain();
    logic [AW-1:0] exp_a [5];
    logic [DW-1:0] exp_d [5];
    exp_a = '{32'h100, 32'h104, 32'h108, 32'h104, 32'h300};
    exp_d = '{32'hA0, 32'hA1, 32'hA2, 32'hBEEF, 32'h33};
    dc_idle = 1'b1;
    store(32'h300, 32'h33);   // R8: arrives while older entries wait
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R4 drain strobe", dc_wr_en, 1);
      chk("R4 R8 drain addr order", dc_wr_addr, exp_a[i]);
      chk("R4 drain data", dc_wr_data, exp_d[i]);
      cyc();
      st_valid = 1'b0;
    end
    #1 chk("R4 drained empty", dc_wr_en, 0);
  endtask

  task automatic t_direct();
    store(32'h400, 32'h44);
    #1;
    chk("R3 direct strobe", dc_wr_en, 1);
    chk("R3 direct addr", dc_wr_addr, 32'h400);
    chk("R3 direct data", dc_wr_data, 32'h44);
    cyc();
    st_valid = 1'b0; ld_addr = 32'h400; #1;
    chk("R3 not held", ld_hit, 0);
  endtask

  task automatic fill(input logic [AW-1:0] base);
    blk_verified = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      store(base + 32'(4 * i), 32'(i));
      #1 chk("R10 accepts up to DEPTH", cpu_stall, 0);
      cyc();
    end
  endtask

  task automatic t_full();
    fill(32'h500);
    store(32'h5F0, 32'h99);
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R6 stall when full", cpu_stall, 1);
      chk("R6 no write", dc_wr_en, 0);
      cyc();
    end
    blk_verified = 1'b1; dc_idle = 1'b1; #1;
    chk("R6 stall released on drain", cpu_stall, 0);
    chk("R6 oldest drains", dc_wr_addr, 32'h500);
    cyc();
    st_valid = 1'b0;
    for (int i = 1; i <= DEPTH; i++) begin
      #1 chk("R6 drain order", dc_wr_addr, (i == DEPTH) ? 32'h5F0 : 32'h500 + 32'(4 * i));
      cyc();
    end
    #1 chk("R6 empty after drain", dc_wr_en, 0);
  endtask

  task automatic t_fail();
    fill(32'h600);
    store(32'h6F0, 32'h66);
    #1 chk("R6 stall before fail", cpu_stall, 1);
    blk_fail = 1'b1; blk_verified = 1'b1; dc_idle = 1'b1; #1;
    chk("R7 stall released", cpu_stall, 0);
    chk("R7 no write on fail", dc_wr_en, 0);
    cyc();
    blk_fail = 1'b0; st_valid = 1'b0; ld_addr = 32'h600; #1;
    chk("R7 nothing drains", dc_wr_en, 0);
    chk("R7 entries gone", ld_hit, 0);
    store(32'h700, 32'h77); #1;
    chk("R7 empty so direct", dc_wr_addr, 32'h700);
    cyc();
    st_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_capture();
    t_busy();
    t_drain();
    t_direct();
    t_full();
    t_fail();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule